// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early Warning

This block is a 7-bit down-counting watchdog that software must refresh inside a window. It runs from the peripheral clock. A fixed prescaler divides that clock by `PRE_DIV` (4096 by default) to form a base tick. A selectable timer-base stage then divides the base tick by 1, 2, 4 or 8. Each resulting count tick decrements the counter by one.

Software arms the watchdog and refreshes it through a control register. A configuration register holds the window value, the timer-base select and the early-warning interrupt enable, and a status register holds the early-warning flag. Once the watchdog is armed, it requests a reset in three cases:

- the counter falls out of its upper range (bit 6 clears on the step from 0x40 to 0x3F);
- software refreshes while the counter is still above the window value;
- software loads a value with bit 6 already clear.

The early-warning flag rises one count before the timeout reset. Distributing the reset across the system is left to the surrounding chip.

Top module: `wwd_top`

## Requirements
- R1: After `rst_n` is released, the counter reads 0x7F, the watchdog is not armed, the window is 0x7F, the timer base is 0, the interrupt enable is 0, the flag is 0, and both `wdg_rst_o` and `early_irq_o` are low.
- R2: The counter decrements by one every `PRE_DIV << tb` clock cycles. `tb` is configuration bits 8:7.
- R3: A write to address 0 (control) loads bits 6:0 into the counter, and bit 7 requests arming. Reading address 0 returns {armed, counter} in bits 7:0.
- R4: Once armed, the watchdog stays armed until `rst_n`, even if a later control write has bit 7 clear.
- R5: While armed, the decrement from 0x40 to 0x3F produces a one-cycle `wdg_rst_o` pulse in the cycle after the counting edge.
- R6: A control write while the watchdog is armed and the current counter is greater than the window value produces a one-cycle `wdg_rst_o` pulse after the write edge.
- R7: A control write that arms or refreshes (armed already, or bit 7 set) with data bit 6 clear produces a one-cycle `wdg_rst_o` pulse after the write edge.
- R8: While not armed, the counter keeps decrementing, wraps from 0x00 to 0x7F, and never raises `wdg_rst_o`. A control write with bit 7 clear in this state never raises it either.
- R9: The decrement from 0x41 to 0x40 sets the flag (status bit 0 at address 2). `early_irq_o` equals the flag AND the enable (configuration bit 9).
- R10: A status write with bit 0 clear clears the flag. A status write with bit 0 set leaves the flag unchanged.
- R11: A write to address 1 stores the window in bits 6:0, the timer base in bits 8:7 and the enable in bit 9, and the same layout reads back. Reading address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 control, 1 configuration, 2 status |
| bus_wen | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 10 | Write data |
| bus_rdata | output | 10 | Read data of the selected register (combinational) |
| wdg_rst_o | output | 1 | One-cycle reset request pulse |
| early_irq_o | output | 1 | Early-warning interrupt level |

## Verification
A wrong counter value shows up on the control read-back within one count tick. Because the window comparison uses that counter, it also turns a legal refresh into a spurious reset pulse, or misses a due one, on the cycle right after the write. A corrupted prescaler or timer-base state shows up as a wrong interval between counter changes within one period of the selected divider. A lost armed bit or early-warning flag is seen at the next count past 0x40, where the reset pulse or the interrupt fails to appear.

// File: rtl/wwd_pkg.sv
package wwd_pkg;

    localparam int CNT_W = 7;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_CFG  = 2'd1,
        REG_STAT = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    localparam logic [CNT_W-1:0] CNT_INIT = 7'h7F;
    localparam logic [CNT_W-1:0] CNT_EDGE = 7'h40;
    localparam logic [CNT_W-1:0] CNT_WARN = 7'h41;

endpackage

// File: rtl/wwd_prescaler.sv
module wwd_prescaler #(
    parameter int PRE_DIV = 4096,
    parameter int TB_W    = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TB_W-1:0] tb_sel,
    output logic            tick
);
    localparam int BASE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam int TBC_W  = (1 << TB_W) - 1;
    localparam logic [BASE_W-1:0] BASE_LAST = BASE_W'(PRE_DIV - 1);

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [TBC_W-1:0]  tbc;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic    base_wrap;
    logic [TBC_W-1:0] tb_mask;

    always_comb begin
        st_d      = st_q;
        base_wrap = (st_q.base == BASE_LAST);
        tb_mask   = ~({TBC_W{1'b1}} << tb_sel);
        tick      = base_wrap && ((st_q.tbc & tb_mask) == tb_mask);
        if (base_wrap) begin
            st_d.base = '0;
            st_d.tbc  = st_q.tbc + 1'b1;
        end else begin
            st_d.base = st_q.base + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    generate
        if (PRE_DIV > 1) begin : g_spacing
            a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/wwd_core.sv
module wwd_core
    import wwd_pkg::*;
#(
    parameter int TB_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wen,
    input  logic [9:0]       bus_wdata,
    output logic [CNT_W-1:0] cnt,
    output logic             armed,
    output logic [CNT_W-1:0] win,
    output logic [TB_W-1:0]  tb_sel,
    output logic             ew_en,
    output logic             ew_flag,
    output logic             rst_pulse
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
        logic [CNT_W-1:0] win;
        logic [TB_W-1:0]  tb;
        logic             ew_en;
        logic             ew_flag;
        logic             rst_pulse;
    } core_st_t;

    localparam core_st_t ST_RESET = '{cnt: CNT_INIT, armed: 1'b0, win: CNT_INIT,
                                      tb: '0, ew_en: 1'b0, ew_flag: 1'b0,
                                      rst_pulse: 1'b0};

    core_st_t st_d, st_q;
    reg_sel_e sel;
    logic     ctrl_wr, cfg_wr, stat_wr, arm_req;

    always_comb begin
        sel     = reg_sel_e'(bus_addr);
        ctrl_wr = bus_wen && (sel == REG_CTRL);
        cfg_wr  = bus_wen && (sel == REG_CFG);
        stat_wr = bus_wen && (sel == REG_STAT);
        arm_req = st_q.armed || bus_wdata[7];

        st_d           = st_q;
        st_d.rst_pulse = 1'b0;

        // flag clear by software; a same-cycle set below wins
        if (stat_wr && !bus_wdata[0]) st_d.ew_flag = 1'b0;

        if (tick) begin
            st_d.cnt = st_q.cnt - 7'd1;
            if (st_q.cnt == CNT_WARN) st_d.ew_flag = 1'b1;
            if (st_q.armed && st_q.cnt == CNT_EDGE) st_d.rst_pulse = 1'b1;
        end

        if (ctrl_wr) begin
            st_d.cnt   = bus_wdata[CNT_W-1:0];
            st_d.armed = arm_req;
            if (st_q.armed && (st_q.cnt > st_q.win)) st_d.rst_pulse = 1'b1;
            if (arm_req && !bus_wdata[6])            st_d.rst_pulse = 1'b1;
        end

        if (cfg_wr) begin
            st_d.win   = bus_wdata[CNT_W-1:0];
            st_d.tb    = bus_wdata[7 +: TB_W];
            st_d.ew_en = bus_wdata[9];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RESET;
        else        st_q <= st_d;
    end

    assign cnt       = st_q.cnt;
    assign armed     = st_q.armed;
    assign win       = st_q.win;
    assign tb_sel    = st_q.tb;
    assign ew_en     = st_q.ew_en;
    assign ew_flag   = st_q.ew_flag;
    assign rst_pulse = st_q.rst_pulse;

    a_r2_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ctrl_wr) |=> (st_q.cnt == $past(st_q.cnt) - 7'd1));
    a_r4_armed_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.armed |=> st_q.armed);
    a_r5_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && st_q.armed && st_q.cnt == CNT_EDGE) |=> st_q.rst_pulse);
    a_r6_early_refresh: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && st_q.armed && st_q.cnt > st_q.win) |=> st_q.rst_pulse);
    a_r7_low_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata[7] && !bus_wdata[6]) |=> st_q.rst_pulse);
    a_r8_quiet_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rst_pulse |-> ($past(st_q.armed) || $past(ctrl_wr && bus_wdata[7])));
    a_r9_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && st_q.cnt == CNT_WARN) |=> st_q.ew_flag);

endmodule

// File: rtl/wwd_rdmux.sv
module wwd_rdmux
    import wwd_pkg::*;
#(
    parameter int TB_W = 2
) (
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] cnt,
    input  logic             armed,
    input  logic [CNT_W-1:0] win,
    input  logic [TB_W-1:0]  tb_sel,
    input  logic             ew_en,
    input  logic             ew_flag,
    output logic [9:0]       bus_rdata
);
    always_comb begin
        bus_rdata = '0;
        unique case (reg_sel_e'(bus_addr))
            REG_CTRL: bus_rdata[7:0] = {armed, cnt};
            REG_CFG:  bus_rdata      = {ew_en, tb_sel, win};
            REG_STAT: bus_rdata[0]   = ew_flag;
            default:  bus_rdata      = '0;
        endcase
    end
endmodule

// File: rtl/wwd_top.sv
module wwd_top #(
    parameter int PRE_DIV = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] bus_addr,
    input  logic       bus_wen,
    input  logic [9:0] bus_wdata,
    output logic [9:0] bus_rdata,
    output logic       wdg_rst_o,
    output logic       early_irq_o
);
    localparam int TB_W = 2;

    logic                     tick;
    logic [wwd_pkg::CNT_W-1:0] cnt, win;
    logic [TB_W-1:0]          tb_sel;
    logic                     armed, ew_en, ew_flag, rst_pulse;

    wwd_prescaler #(.PRE_DIV(PRE_DIV), .TB_W(TB_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .tb_sel(tb_sel), .tick(tick)
    );

    wwd_core #(.TB_W(TB_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .bus_addr(bus_addr), .bus_wen(bus_wen), .bus_wdata(bus_wdata),
        .cnt(cnt), .armed(armed), .win(win), .tb_sel(tb_sel),
        .ew_en(ew_en), .ew_flag(ew_flag), .rst_pulse(rst_pulse)
    );

    wwd_rdmux #(.TB_W(TB_W)) u_rd (
        .bus_addr(bus_addr), .cnt(cnt), .armed(armed), .win(win),
        .tb_sel(tb_sel), .ew_en(ew_en), .ew_flag(ew_flag), .bus_rdata(bus_rdata)
    );

    assign wdg_rst_o   = rst_pulse;
    assign early_irq_o = ew_flag && ew_en;

    a_r9_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        early_irq_o |-> ew_en);

endmodule

// File: tb/sim_wwd_top.sv
module sim_wwd_top;
    localparam int PD = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wen = 1'b0;
    logic [9:0] bus_wdata = '0;
    logic [9:0] bus_rdata;
    logic       wdg_rst_o, early_irq_o;

    int checks = 0;
    int failures = 0;
    int rst_seen = 0;

    always #10 clk = ~clk;

    wwd_top #(.PRE_DIV(PD)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdg_rst_o(wdg_rst_o), .early_irq_o(early_irq_o)
    );

    always @(negedge clk) if (wdg_rst_o) rst_seen++;

    function automatic logic exp_rst(logic armed, logic [6:0] cur,
                                     logic [6:0] win, logic [7:0] wd);
        return (armed && cur > win) || ((armed || wd[7]) && !wd[6]);
    endfunction

    function automatic int exp_period(int tb);
        return PD << tb;
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_wen = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(logic [1:0] a, logic [9:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [9:0] d);
        @(negedge clk);
        bus_addr = a; bus_wen = 1'b0;
        #1 d = bus_rdata;
    endtask

    task automatic wait_cnt(logic [6:0] v);
        logic [9:0] d;
        for (int i = 0; i < 4000; i++) begin
            rd(2'd0, d);
            if (d[6:0] == v) return;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [9:0] d;
        logic [6:0] prev;
        int n, r0;
        void'($urandom(32'd7));

        // R1 reset state
        do_reset();
        rd(2'd0, d); chk("R1 ctrl", d, 10'h07F);
        rd(2'd1, d); chk("R1 cfg", d, 10'h07F);
        rd(2'd2, d); chk("R1 stat", d, 10'h000);
        chk("R1 outputs", {wdg_rst_o, early_irq_o}, 2'b00);

        // R2 / R11 tick period per timer base
        for (int tb = 0; tb < 4; tb++) begin
            wr(2'd1, {1'b0, 2'(tb), 7'h7F});
            rd(2'd1, d); chk("R11 cfg readback", d, {1'b0, 2'(tb), 7'h7F});
            rd(2'd0, d); prev = d[6:0];
            for (int i = 0; i < 100; i++) begin rd(2'd0, d); if (d[6:0] != prev) break; end
            prev = d[6:0]; n = 0;
            for (int i = 0; i < 100; i++) begin n++; rd(2'd0, d); if (d[6:0] != prev) break; end
            chk("R2 period", 16'(n), 16'(exp_period(tb)));
        end
        rd(2'd3, d); chk("R11 addr3 zero", d, 10'h000);

        // R8 unarmed: low load, through 0x40 and wrap, no reset
        do_reset();
        r0 = rst_seen;
        wr(2'd0, 10'h042);
        rd(2'd0, d); chk("R3 load unarmed", {8'h0, d[7:0]}, 16'h0042);
        wait_cnt(7'h3F);
        wait_cnt(7'h7F);
        rd(2'd0, d); chk("R8 wrap", {8'h0, d[7:0]}, 16'h007F);
        chk("R8 no reset", 16'(rst_seen - r0), 16'd0);

        // R4 sticky arming, R6 early refresh
        do_reset();
        wr(2'd1, 10'h050);
        r0 = rst_seen;
        wr(2'd0, 10'h0FF);
        chk("R6 arm no reset", 16'(rst_seen - r0), 16'd0);
        rd(2'd0, d); chk("R3 armed readback", d[7], 1'b1);
        wr(2'd0, 10'h07F);
        chk("R6 early refresh", wdg_rst_o, 1'b1);
        @(negedge clk); chk("R6 pulse width", wdg_rst_o, 1'b0);
        rd(2'd0, d); chk("R4 armed sticky", d[7], 1'b1);

        // R7 arming with bit 6 clear
        do_reset();
        wr(2'd0, 10'h0B0);
        chk("R7 low load", wdg_rst_o, 1'b1);

        // R5 / R9 / R10 timeout path with interrupt enabled
        do_reset();
        wr(2'd1, 10'h27F);
        wr(2'd0, 10'h0C5);
        chk("R5 arm clean", wdg_rst_o, 1'b0);
        wait_cnt(7'h40);
        chk("R9 irq at 0x40", early_irq_o, 1'b1);
        chk("R5 no reset at 0x40", wdg_rst_o, 1'b0);
        wait_cnt(7'h3F);
        chk("R5 timeout pulse", wdg_rst_o, 1'b1);
        wr(2'd2, 10'h001);
        rd(2'd2, d); chk("R10 write one keeps", d, 10'h001);
        wr(2'd2, 10'h000);
        rd(2'd2, d); chk("R10 clear", d, 10'h000);
        chk("R10 irq low", early_irq_o, 1'b0);

        // R9 flag without enable: irq stays low
        do_reset();
        wr(2'd0, 10'h043);
        wait_cnt(7'h40);
        rd(2'd2, d); chk("R9 flag set", d, 10'h001);
        chk("R9 irq gated", early_irq_o, 1'b0);

        // R6 / R7 random refresh sequences
        begin
            logic [6:0] w, cur;
            logic [7:0] wd;
            logic e;
            do_reset();
            w = 7'h40 | 7'($urandom_range(0, 63));
            wr(2'd1, {3'b000, w});
            wr(2'd0, 10'h0FF);
            for (int it = 0; it < 80; it++) begin
                repeat ($urandom_range(0, 20)) @(negedge clk);
                wd[7] = 1'($urandom_range(0, 1));
                wd[6] = ($urandom_range(0, 5) != 0);
                wd[5:0] = wd[6] ? 6'($urandom_range(8, 63)) : 6'($urandom_range(0, 63));
                @(negedge clk);
                bus_addr = 2'd0; bus_wdata = {2'b00, wd}; bus_wen = 1'b1;
                #1 cur = bus_rdata[6:0];
                e = exp_rst(1'b1, cur, w, wd);
                @(negedge clk);
                bus_wen = 1'b0;
                chk(e ? "R6 R7 random reset" : "R6 random quiet", wdg_rst_o, e);
                if (e) begin
                    do_reset();
                    w = 7'h40 | 7'($urandom_range(0, 63));
                    wr(2'd1, {3'b000, w});
                    wr(2'd0, 10'h0FF);
                end
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule